// File: doc/BRIEF.md
# Linear CCD Line Readout Sequencer

This block drives a linear CCD sensor and records one line of pixels per request. It divides the system clock down to the sensor master clock. It then plays out a fixed gate sequence. A shift-gate pulse opens the exposure. A second shift-gate pulse, framed by a low period of the integration-clear gate, ends it. Pixel readout starts when the clear gate returns high.

During readout every pixel lasts four master-clock periods. A sample strobe to an external 16-bit ADC is high for the whole third period, when the analog level has settled. A fixed number of system cycles after the strobe rises, the ADC word is written to a synchronous SRAM. The first pixel of each line goes to address zero, and each later pixel goes to the next address. A one-cycle done pulse marks the end of the line.

The exposure length is a count of master-clock periods, taken when the start request is accepted. All gate and strobe edges line up with rising edges of the master clock.

Top module: `ccd_line_sequencer`

## Requirements
- R1: `mclk_o` has a period of DIV = SYS_CLK_HZ / MCLK_HZ system cycles. It is high for the first DIV/2 cycles of each period and low for the rest. The first high phase begins in the first cycle after reset.
- R2: When idle, a high `start_req` is accepted in the cycle it is sampled (cycle c). The exposure-opening shift-gate pulse on `sh_o` is then high for one master period, with `icg_o` high. That period is the first master period that begins at or after cycle c+2.
- R3: From the falling edge of the opening shift-gate pulse to the falling edge of the transfer pulse is E master periods. E is `exp_periods` as captured in cycle c, and any value below 3 is treated as 3. Changing `exp_periods` during a line has no effect on that line.
- R4: The transfer shift-gate pulse is one master period wide. `icg_o` is low from one master period before that pulse until one master period after it. `icg_o` is high at every other time.
- R5: Readout begins at the rising edge of `icg_o`. Each pixel lasts exactly 4 master periods. `adc_strobe_o` is high throughout the third of them (phase index 2 of 0..3) and low otherwise.
- R6: Call S the first cycle in which `adc_strobe_o` is high. The value on `adc_data` in cycle S+CAP_LAT is written to SRAM: `sram_we_o` is high for one cycle, cycle S+CAP_LAT+1, with that value on `sram_wdata_o`.
- R7: The writes of a line carry `sram_addr_o` values 0, 1, … NUM_PIXELS-1, in order, one per pixel.
- R8: `frame_done_o` is high for exactly one cycle. That cycle is the first cycle after the fourth period of the last pixel. The block is idle in that cycle and can accept a new `start_req` in it.
- R9: A `start_req` sampled while a line is in progress, including the wait for the first master period, is ignored.
- R10: A synchronous reset `rst` returns the block to idle. After reset, `sh_o`, `adc_strobe_o`, `sram_we_o` and `frame_done_o` are low, `icg_o` and `mclk_o` are high, and `sram_addr_o` and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Request to expose and read one line |
| exp_periods | input | EXP_W | Exposure length in master-clock periods |
| adc_data | input | DATA_W | Converted pixel word from the ADC |
| mclk_o | output | 1 | Sensor master clock |
| sh_o | output | 1 | Shift-gate pulse to the sensor |
| icg_o | output | 1 | Integration-clear gate to the sensor |
| adc_strobe_o | output | 1 | ADC sample strobe |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | ADDR_W | SRAM write address |
| sram_wdata_o | output | DATA_W | SRAM write data |
| frame_done_o | output | 1 | One-cycle end-of-line pulse |

## Verification
The bench builds the block with an 8-cycle master period (16 MHz over 2 MHz), six pixels per line and a capture latency of 2. A full line then takes only a few hundred cycles, so the run covers several lines. These include back-to-back lines started in the done cycle, and starts that land on or just before a master-period boundary. They also include exposures below, at and above the minimum of three periods. The same settings let the bench issue start requests and change the exposure during a line, and reset the block partway through its exposure.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_OPEN,
        ST_EXPOSE,
        ST_LEAD,
        ST_XFER,
        ST_TAIL,
        ST_READ
    } seq_state_e;

    localparam int PIXEL_PHASES = 4;
    localparam int STROBE_PHASE = 2;
    localparam int MIN_EXPOSE   = 3;

endpackage

// File: rtl/ccd_mclk_div.sv
module ccd_mclk_div #(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst,
    output logic mclk_o,
    output logic tick_o
);

    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mclk;
    } div_regs_t;

    div_regs_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (div_q.cnt == CW'(DIV - 1)) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
        div_d.mclk = (div_d.cnt < CW'(HALF));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q.cnt  <= '0;
            div_q.mclk <= 1'b1;
        end else begin
            div_q <= div_d;
        end
    end

    assign mclk_o = div_q.mclk;
    assign tick_o = (div_q.cnt == CW'(DIV - 1));

endmodule

// File: rtl/ccd_gate_fsm.sv
module ccd_gate_fsm
    import ccd_seq_pkg::*;
#(
    parameter int EXP_W      = 20,
    parameter int NUM_PIXELS = 3694,
    parameter int PIX_W      = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             sh_o,
    output logic             icg_o,
    output logic             strobe_o,
    output logic             rise_o,
    output logic             done_o,
    output logic             fstart_o
);

    localparam logic [EXP_W-1:0] EXP_MIN  = EXP_W'(MIN_EXPOSE);
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(NUM_PIXELS - 1);
    localparam logic [1:0]       PH_PRE   = 2'(STROBE_PHASE - 1);
    localparam logic [1:0]       PH_STB   = 2'(STROBE_PHASE);
    localparam logic [1:0]       PH_LAST  = 2'(PIXEL_PHASES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [EXP_W-1:0] exp_len;
        logic [EXP_W-1:0] exp_cnt;
        logic [1:0]       phase;
        logic [PIX_W-1:0] pix;
        logic             sh;
        logic             icg;
        logic             strobe;
        logic             rise;
        logic             done;
        logic             fstart;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d        = fsm_q;
        fsm_d.rise   = 1'b0;
        fsm_d.done   = 1'b0;
        fsm_d.fstart = 1'b0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    fsm_d.exp_len = (exp_i < EXP_MIN) ? EXP_MIN : exp_i;
                    fsm_d.st      = ST_ARM;
                    fsm_d.fstart  = 1'b1;
                end
            end
            ST_ARM: begin
                if (tick_i) begin
                    fsm_d.st = ST_OPEN;
                    fsm_d.sh = 1'b1;
                end
            end
            ST_OPEN: begin
                if (tick_i) begin
                    fsm_d.st      = ST_EXPOSE;
                    fsm_d.sh      = 1'b0;
                    fsm_d.exp_cnt = '0;
                end
            end
            ST_EXPOSE: begin
                if (tick_i) begin
                    if (fsm_q.exp_cnt == fsm_q.exp_len - EXP_MIN) begin
                        fsm_d.st  = ST_LEAD;
                        fsm_d.icg = 1'b0;
                    end else begin
                        fsm_d.exp_cnt = fsm_q.exp_cnt + 1'b1;
                    end
                end
            end
            ST_LEAD: begin
                if (tick_i) begin
                    fsm_d.st = ST_XFER;
                    fsm_d.sh = 1'b1;
                end
            end
            ST_XFER: begin
                if (tick_i) begin
                    fsm_d.st = ST_TAIL;
                    fsm_d.sh = 1'b0;
                end
            end
            ST_TAIL: begin
                if (tick_i) begin
                    fsm_d.st    = ST_READ;
                    fsm_d.icg   = 1'b1;
                    fsm_d.phase = '0;
                    fsm_d.pix   = '0;
                end
            end
            ST_READ: begin
                if (tick_i) begin
                    fsm_d.phase = fsm_q.phase + 1'b1;
                    if (fsm_q.phase == PH_PRE) begin
                        fsm_d.strobe = 1'b1;
                        fsm_d.rise   = 1'b1;
                    end
                    if (fsm_q.phase == PH_STB) begin
                        fsm_d.strobe = 1'b0;
                    end
                    if (fsm_q.phase == PH_LAST) begin
                        if (fsm_q.pix == PIX_LAST) begin
                            fsm_d.st   = ST_IDLE;
                            fsm_d.done = 1'b1;
                            fsm_d.pix  = '0;
                        end else begin
                            fsm_d.pix = fsm_q.pix + 1'b1;
                        end
                    end
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q.st      <= ST_IDLE;
            fsm_q.exp_len <= '0;
            fsm_q.exp_cnt <= '0;
            fsm_q.phase   <= '0;
            fsm_q.pix     <= '0;
            fsm_q.sh      <= 1'b0;
            fsm_q.icg     <= 1'b1;
            fsm_q.strobe  <= 1'b0;
            fsm_q.rise    <= 1'b0;
            fsm_q.done    <= 1'b0;
            fsm_q.fstart  <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sh_o     = fsm_q.sh;
    assign icg_o    = fsm_q.icg;
    assign strobe_o = fsm_q.strobe;
    assign rise_o   = fsm_q.rise;
    assign done_o   = fsm_q.done;
    assign fstart_o = fsm_q.fstart;

endmodule

// File: rtl/ccd_capture.sv
module ccd_capture #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 12,
    parameter int CAP_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic              fstart_i,
    input  logic [DATA_W-1:0] adc_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);

    typedef struct packed {
        logic [CAP_LAT-1:0] dly;
        logic [ADDR_W-1:0]  next_addr;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic               we;
    } cap_regs_t;

    cap_regs_t cap_d, cap_q;
    logic [CAP_LAT-1:0] dly_shift;

    generate
        if (CAP_LAT == 1) begin : g_lat_one
            assign dly_shift = rise_i;
        end else begin : g_lat_many
            assign dly_shift = {cap_q.dly[CAP_LAT-2:0], rise_i};
        end
    endgenerate

    always_comb begin
        cap_d     = cap_q;
        cap_d.dly = dly_shift;
        cap_d.we  = 1'b0;
        if (fstart_i) begin
            cap_d.next_addr = '0;
        end
        if (cap_q.dly[CAP_LAT-1]) begin
            cap_d.we        = 1'b1;
            cap_d.addr      = cap_q.next_addr;
            cap_d.wdata     = adc_i;
            cap_d.next_addr = cap_q.next_addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign we_o    = cap_q.we;
    assign addr_o  = cap_q.addr;
    assign wdata_o = cap_q.wdata;

endmodule

// File: rtl/ccd_line_sequencer.sv
module ccd_line_sequencer #(
    parameter int SYS_CLK_HZ = 40_000_000,
    parameter int MCLK_HZ    = 2_000_000,
    parameter int NUM_PIXELS = 3694,
    parameter int EXP_W      = 20,
    parameter int DATA_W     = 16,
    parameter int CAP_LAT    = 3,
    localparam int DIV       = SYS_CLK_HZ / MCLK_HZ,
    localparam int ADDR_W    = (NUM_PIXELS > 1) ? $clog2(NUM_PIXELS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic [EXP_W-1:0]  exp_periods,
    input  logic [DATA_W-1:0] adc_data,
    output logic              mclk_o,
    output logic              sh_o,
    output logic              icg_o,
    output logic              adc_strobe_o,
    output logic              sram_we_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic [DATA_W-1:0] sram_wdata_o,
    output logic              frame_done_o
);

    logic tick;
    logic rise;
    logic fstart;

    ccd_mclk_div #(
        .DIV (DIV)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .mclk_o (mclk_o),
        .tick_o (tick)
    );

    ccd_gate_fsm #(
        .EXP_W      (EXP_W),
        .NUM_PIXELS (NUM_PIXELS),
        .PIX_W      (ADDR_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .start_i  (start_req),
        .exp_i    (exp_periods),
        .sh_o     (sh_o),
        .icg_o    (icg_o),
        .strobe_o (adc_strobe_o),
        .rise_o   (rise),
        .done_o   (frame_done_o),
        .fstart_o (fstart)
    );

    ccd_capture #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .CAP_LAT (CAP_LAT)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .rise_i   (rise),
        .fstart_i (fstart),
        .adc_i    (adc_data),
        .we_o     (sram_we_o),
        .addr_o   (sram_addr_o),
        .wdata_o  (sram_wdata_o)
    );

endmodule

// File: rtl/ccd_line_sequencer_chk.sv
module ccd_line_sequencer_chk #(
    parameter int DIV    = 20,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              mclk_o,
    input logic              sh_o,
    input logic              icg_o,
    input logic              adc_strobe_o,
    input logic              sram_we_o,
    input logic [ADDR_W-1:0] sram_addr_o,
    input logic              frame_done_o
);

    localparam int PW = $clog2(DIV + 2) + 1;

    logic [PW-1:0]     per_cnt_q;
    logic              mclk_prev_q;
    logic              sh_prev_q;
    logic [ADDR_W-1:0] wr_cnt_q;
    logic              rst_prev_q;

    always_ff @(posedge clk) begin
        rst_prev_q <= rst;
        if (rst) begin
            per_cnt_q   <= '0;
            mclk_prev_q <= 1'b1;
            sh_prev_q   <= 1'b0;
            wr_cnt_q    <= '0;
        end else begin
            mclk_prev_q <= mclk_o;
            sh_prev_q   <= sh_o;
            if (mclk_o && !mclk_prev_q) begin
                per_cnt_q <= PW'(1);
            end else if (per_cnt_q != {PW{1'b1}}) begin
                per_cnt_q <= per_cnt_q + 1'b1;
            end
            if (sh_o && !sh_prev_q && icg_o) begin
                wr_cnt_q <= '0;
            end else if (sram_we_o) begin
                wr_cnt_q <= wr_cnt_q + 1'b1;
            end
        end
    end

    assert_mclk_period_R1: assert property (@(posedge clk) disable iff (rst)
        (mclk_o && !mclk_prev_q) |-> (per_cnt_q == PW'(DIV)));

    assert_sh_on_mclk_edge_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sh_o) |-> $rose(mclk_o));

    assert_icg_edges_sh_low_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(icg_o) || $rose(icg_o)) |-> !sh_o);

    assert_strobe_in_readout_R5: assert property (@(posedge clk) disable iff (rst)
        adc_strobe_o |-> (icg_o && !sh_o));

    assert_strobe_on_mclk_edge_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_strobe_o) |-> $rose(mclk_o));

    assert_addr_sequence_R7: assert property (@(posedge clk) disable iff (rst)
        sram_we_o |-> (sram_addr_o == wr_cnt_q));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |=> !frame_done_o);

    always_ff @(posedge clk) begin
        if (!rst && rst_prev_q) begin
            assert_reset_state_R10: assert (!sh_o && icg_o && mclk_o && !adc_strobe_o
                                            && !sram_we_o && !frame_done_o
                                            && (sram_addr_o == '0));
        end
    end

endmodule

bind ccd_line_sequencer ccd_line_sequencer_chk #(
    .DIV    (DIV),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mclk_o       (mclk_o),
    .sh_o         (sh_o),
    .icg_o        (icg_o),
    .adc_strobe_o (adc_strobe_o),
    .sram_we_o    (sram_we_o),
    .sram_addr_o  (sram_addr_o),
    .frame_done_o (frame_done_o)
);

// File: tb/ccd_line_sequencer_bench.sv
`timescale 1ns/1ps
module ccd_line_sequencer_bench;

    localparam int SYS_HZ = 16_000_000;
    localparam int MC_HZ  = 2_000_000;
    localparam int NPIX   = 6;
    localparam int LAT    = 2;
    localparam int EW     = 20;
    localparam int DW     = 16;
    localparam int AW     = 3;
    localparam longint P  = SYS_HZ / MC_HZ;
    localparam longint HF = P / 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_req = 1'b0;
    logic [EW-1:0] exp_periods = '0;
    logic [DW-1:0] adc_data = '0;
    logic          mclk_o, sh_o, icg_o, adc_strobe_o, sram_we_o, frame_done_o;
    logic [AW-1:0] sram_addr_o;
    logic [DW-1:0] sram_wdata_o;

    always #2.5 clk = ~clk;

    ccd_line_sequencer #(
        .SYS_CLK_HZ (SYS_HZ),
        .MCLK_HZ    (MC_HZ),
        .NUM_PIXELS (NPIX),
        .EXP_W      (EW),
        .DATA_W     (DW),
        .CAP_LAT    (LAT)
    ) u_ccd_line_sequencer (
        .clk          (clk),
        .rst          (rst),
        .start_req    (start_req),
        .exp_periods  (exp_periods),
        .adc_data     (adc_data),
        .mclk_o       (mclk_o),
        .sh_o         (sh_o),
        .icg_o        (icg_o),
        .adc_strobe_o (adc_strobe_o),
        .sram_we_o    (sram_we_o),
        .sram_addr_o  (sram_addr_o),
        .sram_wdata_o (sram_wdata_o),
        .frame_done_o (frame_done_o)
    );

    int     n_cmp = 0;
    int     n_bad = 0;
    bit     finished = 0;
    longint cyc = 0;
    bit     fr_valid = 0;
    longint fr_b0, fr_e, fr_r0, fr_end;

    function automatic logic [DW-1:0] adc_val(longint k);
        return DW'((k * 40503 + 17) & 16'hFFFF);
    endfunction

    function automatic bit busy(longint k);
        return fr_valid && (k < fr_end);
    endfunction

    function automatic bit in_win(longint k, longint lo, longint hi);
        return (k >= lo) && (k < hi);
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: got %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic check_cycle();
        longint k = cyc;
        bit e_sh = 0, e_icg = 1, e_stb = 0, e_done = 0, e_we = 0;
        longint e_addr = 0;
        longint j;
        if (fr_valid) begin
            e_sh  = in_win(k, fr_b0, fr_b0 + P) || in_win(k, fr_b0 + fr_e * P, fr_b0 + (fr_e + 1) * P);
            e_icg = !in_win(k, fr_b0 + (fr_e - 1) * P, fr_b0 + (fr_e + 2) * P);
            e_stb = in_win(k, fr_r0, fr_end) && (((k - fr_r0) / P) % 4 == 2);
            e_done = (k == fr_end);
            j = k - (fr_r0 + 2 * P + LAT + 1);
            if (j >= 0 && (j % (4 * P)) == 0 && (j / (4 * P)) < NPIX) begin
                e_we   = 1;
                e_addr = j / (4 * P);
            end
        end
        chk("R1 mclk", mclk_o, ((k % P) < HF) ? 1 : 0);
        chk((k == 0) ? "R10 sh" : "R3 sh", sh_o, e_sh);
        chk((k == 0) ? "R10 icg" : "R4 icg", icg_o, e_icg);
        chk((k == 0) ? "R10 strobe" : "R5 strobe", adc_strobe_o, e_stb);
        chk((k == 0) ? "R10 done" : "R8 done", frame_done_o, e_done);
        chk((k == 0) ? "R10 we" : "R6 we", sram_we_o, e_we);
        if (k == 0) chk("R10 addr", sram_addr_o, 0);
        if (e_we && sram_we_o) begin
            chk("R7 addr", sram_addr_o, e_addr);
            chk("R6 data", sram_wdata_o, adc_val(k - 1));
        end
    endtask

    // one cycle: compare this cycle, drive its inputs, update model, advance
    task automatic run_cycle(input bit st, input longint ex);
        check_cycle();
        start_req   = st;
        exp_periods = EW'(ex);
        adc_data    = adc_val(cyc);
        if (st && !busy(cyc)) begin
            fr_valid = 1;
            fr_b0  = ((cyc + 2 + P - 1) / P) * P;
            fr_e   = (ex < 3) ? 3 : ex;
            fr_r0  = fr_b0 + (fr_e + 2) * P;
            fr_end = fr_r0 + 4 * NPIX * P;
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        start_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        fr_valid = 0;
    endtask

    // wait out a line (R9: stray starts and exposure changes while busy), then start
    task automatic line(input longint gap, input longint align, input longint ex);
        while (busy(cyc)) run_cycle((cyc % 50) == 25, 2);
        for (int g = 0; g < gap; g++) run_cycle(0, 2);
        if (align >= 0) while ((cyc % P) != align) run_cycle(0, 2);
        run_cycle(1, ex);
    endtask

    initial begin
        do_reset();
        line(3, -1, 5);            // R2 R3 basic exposure
        line(0, -1, 0);            // R8 start in done cycle, R3 clamp to 3
        line(1, P - 1, 3);         // R2 start on master-period boundary
        line(2, P - 2, 10);        // R2 earliest opening, long exposure
        line(0, -1, 1);            // R3 clamp again, back to back
        line(4, -1, 4);
        while (cyc < fr_b0 + 3 * P) run_cycle(0, 2);
        do_reset();                // R10 reset during exposure
        for (int g = 0; g < 20; g++) run_cycle(0, 2);
        line(2, -1, 4);
        while (busy(cyc)) run_cycle(0, 2);
        for (int g = 0; g < 12; g++) run_cycle(0, 2);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule